// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer for 9-bit words. Its write port and its read port run on clocks that are not related to each other. The write side reports full and almost-full. The read side reports empty and almost-empty. All four flags are active low. The read data register has a separate drive-enable output, which models a bus that the output enable can release to high impedance.

One write-side input, `wr_multi`, serves two purposes. Its level while reset is in effect picks its role until the next reset:

- High: it becomes a second write enable.
- Low: it becomes a strobe that loads the two flag thresholds through the data bus, one byte at a time.

Pointers cross between the clock domains as Gray code through two-flop synchronisers. As a result, a word written into an empty buffer becomes visible to the reader after a short, bounded delay.

Top module: `progflag_fifo`

## Requirements
- R1: While `rst_n` is low, `empty_n` and `almost_empty_n` are 0, and `full_n` and `almost_full_n` are 1.
- R2: During and after reset, `dout` is 0 until the first read. `dout_drive` always equals `rd_oe`.
- R3: If `wr_multi` was 1 during reset, a word is written only when `wr_en` and `wr_multi` are both 1. A write attempt with `wr_multi` at 0 leaves the buffer empty.
- R4: If `wr_multi` was 0 during reset, two cases apply.
  - A cycle with `wr_en` and `wr_multi` both 1 stores `din[7:0]` into the next threshold byte and writes no data. The byte order is almost-empty low byte (bits 7:0), almost-empty high byte (bits 15:8), almost-full low byte, almost-full high byte, and the order wraps after the fourth byte.
  - A cycle with `wr_en` at 1 and `wr_multi` at 0 writes a data word.
- R5: A read happens only when `rd_en_a` and `rd_en_b` are both 1. With only one of them at 1, the stored word is kept and `dout` does not change.
- R6: Words come out of `dout` in the order they were written, with all 9 bits intact.
- R7: `full_n` goes to 0 when 64 words are held. A write while full is ignored, and no stored word is overwritten.
- R8: A read while empty is ignored. `dout` keeps its last value and `empty_n` stays 0.
- R9: `almost_empty_n` is 0 when the occupancy seen on the read side is at or below the almost-empty threshold. The threshold after reset is 7.
- R10: `almost_full_n` is 0 when the free space seen on the write side is at or below the almost-full threshold. The threshold after reset is 7.
- R11: After a write into an empty buffer:
  - `empty_n` rises on the second or third read-clock edge after the write edge.
  - The word appears on `dout` at the read-clock edge that follows the rise of `empty_n`, never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_multi | input | 1 | Second write enable or threshold load strobe, role sampled during reset |
| din | input | 9 | Write data; bits 7:0 also carry threshold bytes |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_oe | input | 1 | Output enable for the read bus |
| dout | output | 9 | Registered read data |
| dout_drive | output | 1 | 1 when `dout` is driven, 0 for high impedance |
| empty_n | output | 1 | Empty flag, active low |
| almost_empty_n | output | 1 | Almost-empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| almost_full_n | output | 1 | Almost-full flag, active low |

## Verification
The buffer is driven with several distinct patterns:

- A single word into an empty buffer, with both read enables already held. This measures the empty-boundary latency and shows that the word does not appear early.
- A steady fill to the top. This separates the default thresholds from the full point, and the one-word-past-full write shows whether a stored word gets overwritten.
- Reads with only one enable raised, and reads into an empty buffer. These show whether a pointer moves when it should not.
- A reset in load mode followed by five strobes. This shows whether the byte order wraps, because only a wrapped fifth byte moves the almost-empty threshold to 4.

// File: rtl/pf_fifo_pkg.sv
`timescale 1ns/100ps
package pf_fifo_pkg;
  localparam int CFG_W  = 16;
  localparam int BYTE_W = 8;
  typedef logic [CFG_W-1:0] cfg_t;

  // threshold byte slots, visited in this order by load strobes
  typedef enum logic [1:0] {
    SLOT_AE_LO = 2'd0,
    SLOT_AE_HI = 2'd1,
    SLOT_AF_LO = 2'd2,
    SLOT_AF_HI = 2'd3
  } slot_e;

  function automatic cfg_t to_gray(input cfg_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic cfg_t from_gray(input cfg_t g);
    cfg_t b;
    b[CFG_W-1] = g[CFG_W-1];
    for (int i = CFG_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // flag rule shared by both sides: amount at or below margin
  function automatic logic within_margin(input cfg_t amount, input cfg_t margin);
    return amount <= margin;
  endfunction
endpackage

// File: rtl/pf_sync.sv
`timescale 1ns/100ps
module pf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pf_wr_ctrl.sv
`timescale 1ns/100ps
module pf_wr_ctrl
  import pf_fifo_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int OFF_DEFAULT = 7
) (
  input  logic              wclk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_multi,
  input  logic [BYTE_W-1:0] cfg_byte,
  input  logic [ADDR_W:0]   r_gray_s,
  output logic [ADDR_W:0]   w_bin,
  output logic [ADDR_W:0]   w_gray,
  output logic [ADDR_W-1:0] w_addr,
  output logic              mem_we,
  output logic              load_fire,
  output logic              full_n,
  output logic              almost_full_n,
  output cfg_t              ae_off,
  output cfg_t              af_off
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic w_live;
  pf_sync #(.W(1)) u_rst_sync (.clk(wclk), .rst_n(rst_n), .d(1'b1), .q(w_live));

  // role of wr_multi, captured on every edge while synchronised reset holds
  logic multi_is_enable;
  always_ff @(posedge wclk) begin
    if (!w_live) multi_is_enable <= wr_multi;
  end

  logic [PW-1:0] r_bin_s, level, room;
  logic          is_full, data_req;

  assign r_bin_s  = PW'(from_gray(cfg_t'(r_gray_s)));
  assign level    = w_bin - r_bin_s;
  assign room     = PW'(DEPTH) - level;
  assign is_full  = (level == PW'(DEPTH));
  assign data_req = multi_is_enable ? (wr_en && wr_multi) : (wr_en && !wr_multi);

  assign mem_we        = w_live && data_req && !is_full;
  assign load_fire     = w_live && !multi_is_enable && wr_en && wr_multi;
  assign full_n        = !w_live || !is_full;
  assign almost_full_n = !w_live || !within_margin(cfg_t'(room), af_off);
  assign w_addr        = w_bin[ADDR_W-1:0];

  logic [PW-1:0] w_bin_nx;
  assign w_bin_nx = w_bin + PW'(1);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      w_bin  <= '0;
      w_gray <= '0;
    end else if (mem_we) begin
      w_bin  <= w_bin_nx;
      w_gray <= PW'(to_gray(cfg_t'(w_bin_nx)));
    end
  end

  slot_e slot_q;
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_AE_LO;
      ae_off <= cfg_t'(OFF_DEFAULT);
      af_off <= cfg_t'(OFF_DEFAULT);
    end else if (load_fire) begin
      case (slot_q)
        SLOT_AE_LO: ae_off[BYTE_W-1:0]       <= cfg_byte;
        SLOT_AE_HI: ae_off[CFG_W-1:BYTE_W]   <= cfg_byte;
        SLOT_AF_LO: af_off[BYTE_W-1:0]       <= cfg_byte;
        default:    af_off[CFG_W-1:BYTE_W]   <= cfg_byte;
      endcase
      slot_q <= slot_e'(slot_q + 2'd1);
    end
  end
endmodule

// File: rtl/pf_rd_ctrl.sv
`timescale 1ns/100ps
module pf_rd_ctrl
  import pf_fifo_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 9
) (
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              rd_oe,
  input  logic [ADDR_W:0]   w_gray_s,
  input  cfg_t              ae_off,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W:0]   r_bin,
  output logic [ADDR_W:0]   r_gray,
  output logic [ADDR_W-1:0] r_addr,
  output logic              rd_fire,
  output logic [DATA_W-1:0] dout,
  output logic              dout_drive,
  output logic              empty_n,
  output logic              almost_empty_n
);
  localparam int PW = ADDR_W + 1;

  logic r_live;
  pf_sync #(.W(1)) u_rst_sync (.clk(rclk), .rst_n(rst_n), .d(1'b1), .q(r_live));

  logic [PW-1:0] w_bin_s, level, r_bin_nx;
  logic          is_empty;

  assign w_bin_s   = PW'(from_gray(cfg_t'(w_gray_s)));
  assign level     = w_bin_s - r_bin;
  assign is_empty  = (level == '0);
  assign r_bin_nx  = r_bin + PW'(1);
  assign r_addr    = r_bin[ADDR_W-1:0];

  assign rd_fire        = r_live && rd_en_a && rd_en_b && !is_empty;
  assign empty_n        = r_live && !is_empty;
  assign almost_empty_n = r_live && !within_margin(cfg_t'(level), ae_off);
  assign dout_drive     = rd_oe;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      r_bin  <= '0;
      r_gray <= '0;
      dout   <= '0;
    end else if (rd_fire) begin
      r_bin  <= r_bin_nx;
      r_gray <= PW'(to_gray(cfg_t'(r_bin_nx)));
      dout   <= rd_word;
    end
  end
endmodule

// File: rtl/progflag_fifo.sv
`timescale 1ns/100ps
module progflag_fifo
  import pf_fifo_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 9,
  parameter int OFF_DEFAULT = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_multi,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              rd_oe,
  output logic [DATA_W-1:0] dout,
  output logic              dout_drive,
  output logic              empty_n,
  output logic              almost_empty_n,
  output logic              full_n,
  output logic              almost_full_n
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  // named internal events, also observed by the bound checker
  logic [PW-1:0]     w_bin, w_gray, r_bin, r_gray, w_gray_s, r_gray_s;
  logic [ADDR_W-1:0] w_addr, r_addr;
  logic              mem_we, load_fire, rd_fire;
  cfg_t              ae_off, af_off;
  logic [DATA_W-1:0] rd_word;

  pf_wr_ctrl #(.ADDR_W(ADDR_W), .OFF_DEFAULT(OFF_DEFAULT)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .wr_multi(wr_multi),
    .cfg_byte(din[BYTE_W-1:0]), .r_gray_s(r_gray_s),
    .w_bin(w_bin), .w_gray(w_gray), .w_addr(w_addr),
    .mem_we(mem_we), .load_fire(load_fire),
    .full_n(full_n), .almost_full_n(almost_full_n),
    .ae_off(ae_off), .af_off(af_off)
  );

  pf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(w_gray), .q(w_gray_s));
  pf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(r_gray), .q(r_gray_s));

  logic [DATA_W-1:0] mem [DEPTH];
  always_ff @(posedge wclk) begin
    if (mem_we) mem[w_addr] <= din;
  end
  assign rd_word = mem[r_addr];

  pf_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
    .rd_oe(rd_oe), .w_gray_s(w_gray_s), .ae_off(ae_off), .rd_word(rd_word),
    .r_bin(r_bin), .r_gray(r_gray), .r_addr(r_addr), .rd_fire(rd_fire),
    .dout(dout), .dout_drive(dout_drive),
    .empty_n(empty_n), .almost_empty_n(almost_empty_n)
  );
endmodule

// File: rtl/pf_fifo_checker.sv
`timescale 1ns/100ps
module pf_fifo_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 9
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              rd_en_a,
  input logic              rd_en_b,
  input logic              empty_n,
  input logic              almost_empty_n,
  input logic              full_n,
  input logic              almost_full_n,
  input logic [DATA_W-1:0] dout,
  input logic [ADDR_W:0]   w_bin,
  input logic [ADDR_W:0]   r_bin,
  input logic [ADDR_W:0]   w_gray,
  input logic [ADDR_W:0]   r_gray,
  input logic              load_fire,
  input logic              mem_we
);
  always @(negedge wclk) begin
    if (!rst_n) begin
      assert_reset_flags_R1: assert (!empty_n && !almost_empty_n && full_n && almost_full_n)
        else $error("reset flag state wrong");
    end
  end

  assert_load_no_data_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    load_fire |-> !mem_we);

  assert_both_enables_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    !(rd_en_a && rd_en_b) |=> $stable(r_bin) && $stable(dout));

  assert_wptr_gray_R6: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(w_gray ^ $past(w_gray)));

  assert_rptr_gray_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    $onehot0(r_gray ^ $past(r_gray)));

  assert_no_overflow_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(w_bin));

  assert_no_underflow_R8: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(r_bin) && $stable(dout));
endmodule

bind progflag_fifo pf_fifo_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
  .empty_n(empty_n), .almost_empty_n(almost_empty_n), .full_n(full_n),
  .almost_full_n(almost_full_n), .dout(dout), .w_bin(w_bin), .r_bin(r_bin),
  .w_gray(w_gray), .r_gray(r_gray), .load_fire(load_fire), .mem_we(mem_we)
);

// File: tb/progflag_fifo_tb.sv
`timescale 1ns/100ps
module progflag_fifo_tb;
  localparam int DEPTH = 64;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_en = 0, wr_multi = 1, rd_en_a = 0, rd_en_b = 0, rd_oe = 1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic dout_drive, empty_n, almost_empty_n, full_n, almost_full_n;

  always #4 wclk = ~wclk;      // 125 MHz write clock
  always #5.5 rclk = ~rclk;

  progflag_fifo u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_multi(wr_multi),
    .din(din), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .rd_oe(rd_oe),
    .dout(dout), .dout_drive(dout_drive), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n), .full_n(full_n), .almost_full_n(almost_full_n)
  );

  int n_tests = 0, n_fail = 0;
  logic [8:0] exp_q[$];
  logic [8:0] last_dout = '0;
  bit load_mode = 0;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: predicts reads from port levels, compares results
  initial begin
    logic fire_p, idle_p;
    logic [8:0] e;
    forever begin
      @(negedge rclk); #1;
      fire_p = rst_n && rd_en_a && rd_en_b && empty_n;
      idle_p = rst_n && rd_en_a && rd_en_b && !empty_n;
      @(posedge rclk); #1;
      if (!rst_n) last_dout = '0;
      else if (fire_p) begin
        if (exp_q.size() == 0) check(1'b0, "R6 read with nothing expected", dout, 0);
        else begin
          e = exp_q.pop_front();
          check(dout == e, "R6 order", dout, e);
        end
        last_dout = dout;
      end else if (idle_p) check(dout == last_dout, "R8 hold while empty", dout, last_dout);
    end
  end

  // driver: one data write, expected item queued when it is accepted
  task automatic push(input logic [8:0] w);
    @(negedge wclk);
    din = w; wr_en = 1; wr_multi = load_mode ? 1'b0 : 1'b1;
    @(posedge wclk);
    if (exp_q.size() < DEPTH) exp_q.push_back(w);
    @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic load_byte(input logic [8:0] v);
    @(negedge wclk);
    din = v; wr_en = 1; wr_multi = 1;
    @(negedge wclk);
    wr_en = 0; wr_multi = 0;
  endtask

  task automatic set_rd(input logic a, input logic b);
    @(negedge rclk);
    rd_en_a = a; rd_en_b = b;
  endtask

  task automatic do_reset(input logic multi);
    rst_n = 0; wr_en = 0; rd_en_a = 0; rd_en_b = 0; wr_multi = multi;
    exp_q.delete();
    repeat (3) @(negedge wclk);
    check(!empty_n, "R1 empty_n in reset", empty_n, 0);
    check(!almost_empty_n, "R1 almost_empty_n in reset", almost_empty_n, 0);
    check(full_n, "R1 full_n in reset", full_n, 1);
    check(almost_full_n, "R1 almost_full_n in reset", almost_full_n, 1);
    check(dout == 9'h0, "R2 dout low in reset", dout, 0);
    check(dout_drive == rd_oe, "R2 drive follows oe", dout_drive, rd_oe);
    rst_n = 1;
    repeat (4) @(negedge wclk);
    repeat (3) @(negedge rclk);
    load_mode = !multi;
    wr_multi = multi;
  endtask

  task automatic drain();
    int guard = 0;
    set_rd(1, 1);
    while (exp_q.size() != 0 && guard < 4000) begin
      @(negedge rclk); guard++;
    end
    repeat (4) @(negedge rclk);
    check(exp_q.size() == 0, "R6 all words read", exp_q.size(), 0);
    check(!empty_n, "R8 empty after drain", empty_n, 0);
    set_rd(0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lat;
    logic [8:0] w;
    do_reset(1'b1);
    check(dout == 9'h0, "R2 dout low after reset", dout, 0);
    rd_oe = 0; #1;
    check(dout_drive == 1'b0, "R2 drive released", dout_drive, 0);
    rd_oe = 1; #1;
    check(dout_drive == 1'b1, "R2 drive enabled", dout_drive, 1);

    // R11 first word at empty boundary, both read enables already held
    set_rd(1, 1);
    @(negedge wclk); din = 9'h1A5; wr_en = 1; wr_multi = 1;
    @(posedge wclk); exp_q.push_back(9'h1A5);
    fork begin @(negedge wclk); wr_en = 0; end join_none
    lat = 0;
    while (lat < 6) begin
      @(posedge rclk); #1; lat++;
      if (empty_n) break;
    end
    check(lat == 2 || lat == 3, "R11 empty_n rise latency", lat, 2);
    check(dout != 9'h1A5, "R11 word not early", dout, 0);
    @(posedge rclk); #1;
    check(dout == 9'h1A5, "R11 word after flag", dout, 9'h1A5);
    set_rd(0, 0);

    // R5 one read enable is not enough
    push(9'h055);
    repeat (5) @(negedge rclk);
    set_rd(1, 0);
    repeat (6) @(negedge rclk);
    check(empty_n, "R5 word kept with one enable", empty_n, 1);
    check(dout == 9'h1A5, "R5 dout unchanged", dout, 9'h1A5);
    set_rd(1, 1);
    repeat (4) @(negedge rclk);
    check(dout == 9'h055, "R5 read with both enables", dout, 9'h055);

    // R8 reads into an empty buffer
    repeat (6) @(negedge rclk);
    check(!empty_n, "R8 stays empty", empty_n, 0);
    check(dout == 9'h055, "R8 dout held", dout, 9'h055);
    set_rd(0, 0);

    // R3 second write enable low blocks the write
    @(negedge wclk); din = 9'h1FF; wr_en = 1; wr_multi = 0;
    @(negedge wclk); wr_en = 0; wr_multi = 1;
    repeat (5) @(negedge rclk);
    check(!empty_n, "R3 write blocked by second enable", empty_n, 0);

    // R9 R10 R7 fill with default thresholds
    for (int i = 1; i <= DEPTH; i++) begin
      w = 9'(i * 37 + 3);
      push(w);
      if (i == 7 || i == 8) begin
        repeat (4) @(negedge rclk);
        check(almost_empty_n == (i == 8), "R9 almost-empty at default", almost_empty_n, (i == 8));
      end
      if (i == 56) check(almost_full_n, "R10 free 8", almost_full_n, 1);
      if (i == 57) check(!almost_full_n, "R10 free 7", almost_full_n, 0);
      if (i == 63) check(full_n, "R7 not full at 63", full_n, 1);
      if (i == 64) check(!full_n, "R7 full at 64", full_n, 0);
    end
    push(9'h0AA);
    check(!full_n, "R7 still full after extra write", full_n, 0);
    drain();
    check(dout == 9'(DEPTH * 37 + 3), "R7 last word not overwritten", dout, 9'(DEPTH * 37 + 3));
    repeat (4) @(negedge wclk);
    check(full_n, "R7 full cleared after drain", full_n, 1);

    // R2 reset while dout holds data, choose load mode
    push(9'h011); push(9'h022);
    do_reset(1'b0);
    check(dout == 9'h0, "R2 dout cleared by reset", dout, 0);

    // R4 five strobes: AE lo=3, AE hi=0, AF lo=2, AF hi=0, wrap AE lo=4
    load_byte(9'h003); load_byte(9'h000); load_byte(9'h002); load_byte(9'h000);
    load_byte(9'h004);
    repeat (5) @(negedge rclk);
    check(!empty_n, "R4 loads write no data", empty_n, 0);
    for (int i = 1; i <= 62; i++) begin
      push(9'(i * 11 + 5));
      if (i == 4 || i == 5) begin
        repeat (4) @(negedge rclk);
        check(almost_empty_n == (i == 5), "R4 almost-empty threshold 4 after wrap", almost_empty_n, (i == 5));
      end
      if (i == 61) check(almost_full_n, "R4 almost-full free 3", almost_full_n, 1);
      if (i == 62) check(!almost_full_n, "R4 almost-full free 2", almost_full_n, 0);
    end
    drain();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule